// File: doc/BRIEF.md
# Queue Interrupt Condition Selector

This block turns the status flags of 64 hardware queues into two interrupt lines, one for the lower 32 queues and one for the upper 32. Every queue reports four live flags: empty, nearly empty, nearly full and full. For each lower queue, software programs a 3-bit source code that picks one flag and may invert it. The upper queues always raise their condition when the queue is not nearly empty.

A rising edge of a queue's condition sets that queue's bit in its half's sticky status register. Software clears a status bit by writing a 1 to it. Each interrupt line is the OR of its half's status bits after masking with that half's enable register. All registers sit behind a small single-cycle write port with a combinational read path. The queues themselves are outside this block.

Top module: `qis_top`

## Requirements
- R1: After reset every source field, both enable words and both status words are zero, every register address reads 0, and both interrupt outputs are low.
- R2: Queue q (0..31) takes its source from bits [4*(q%8)+2 : 4*(q%8)] of source word q/8 (addresses 0..3). Code bits [1:0] pick the flag (0 empty, 1 nearly empty, 2 nearly full, 3 full), and code bit 2 inverts it.
- R3: Bit 3 of every 4-bit source field is reserved. It always reads 0, and a 1 written to it is dropped.
- R4: Queues 32..63 always use "not nearly empty" as their condition. No register write changes this.
- R5: A status bit is set in the cycle after its queue's condition goes from 0 to 1. It stays set after the condition falls, and a condition that stays high does not set the bit again once it has been cleared.
- R6: A write to a status word (address 6 for the lower half, 7 for the upper half) clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R7: If a rising edge and a write-1 clear hit the same status bit in the same cycle, the bit ends up set.
- R8: irq_lo is high exactly when some bit of status word 6 and the same bit of enable word 4 are both 1. irq_hi follows the same rule for words 7 and 5. Status bits latch whether or not they are enabled.
- R9: Enable words are written and read back at address 4 (lower half, bit n = queue n) and address 5 (upper half, bit n = queue 32+n). Status words read back at addresses 6 and 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| q_empty | input | 64 | Per-queue empty flag |
| q_near_empty | input | 64 | Per-queue nearly-empty flag |
| q_near_full | input | 64 | Per-queue nearly-full flag |
| q_full | input | 64 | Per-queue full flag |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| irq_lo | output | 1 | Interrupt for queues 0..31 |
| irq_hi | output | 1 | Interrupt for queues 32..63 |

## Verification
The assertions assume that the queue flags are synchronous to clk and held low or stable through reset. Flags that are already high when reset is released are treated as rising edges, so the bench keeps every selected condition low during reset. In particular, it holds all nearly-empty flags high while reset is asserted. The bench changes flags and bus signals only on the falling edge, so each rising edge of a condition and each clear write fall in one well-defined cycle. This includes the case where both hit the same bit in the same cycle.

// File: rtl/qis_pkg.sv
package qis_pkg;

    // Flag index selected by source code bits [1:0]
    typedef enum logic [1:0] {
        FLG_EMPTY      = 2'd0,
        FLG_NEAR_EMPTY = 2'd1,
        FLG_NEAR_FULL  = 2'd2,
        FLG_FULL       = 2'd3
    } flag_sel_e;

    // Fixed code for the upper half: nearly-empty, inverted
    localparam logic [2:0] CODE_NOT_NEAR_EMPTY = 3'b101;

    // Evaluate one queue's interrupt condition from its code and flags
    function automatic logic qis_eval(input logic [2:0] code,
                                      input logic e, input logic ne,
                                      input logic nf, input logic f);
        logic picked;
        case (flag_sel_e'(code[1:0]))
            FLG_EMPTY:      picked = e;
            FLG_NEAR_EMPTY: picked = ne;
            FLG_NEAR_FULL:  picked = nf;
            default:        picked = f;
        endcase
        return picked ^ code[2];
    endfunction

endpackage

// File: rtl/qis_cond_sel.sv
module qis_cond_sel
    import qis_pkg::*;
#(
    parameter int         NQ         = 32,
    parameter int         FIELD_W    = 4,
    parameter bit         PROG       = 1'b1,
    parameter logic [2:0] FIXED_CODE = CODE_NOT_NEAR_EMPTY
) (
    input  logic [NQ*FIELD_W-1:0] src_i,
    input  logic [NQ-1:0]         empty_i,
    input  logic [NQ-1:0]         near_empty_i,
    input  logic [NQ-1:0]         near_full_i,
    input  logic [NQ-1:0]         full_i,
    output logic [NQ-1:0]         cond_o
);

    generate
        if (PROG) begin : g_prog
            for (genvar q = 0; q < NQ; q++) begin : g_q
                logic [2:0] code;
                assign code      = src_i[q*FIELD_W +: 3];
                assign cond_o[q] = qis_eval(code, empty_i[q], near_empty_i[q],
                                            near_full_i[q], full_i[q]);
            end
        end else begin : g_fixed
            logic unused_src;
            assign unused_src = ^src_i;
            for (genvar q = 0; q < NQ; q++) begin : g_q
                assign cond_o[q] = qis_eval(FIXED_CODE, empty_i[q], near_empty_i[q],
                                            near_full_i[q], full_i[q]);
            end
        end
    endgenerate

endmodule

// File: rtl/qis_latch_bank.sv
module qis_latch_bank #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] cond_i,
    input  logic         clr_we_i,
    input  logic [W-1:0] clr_mask_i,
    output logic [W-1:0] set_o,
    output logic [W-1:0] stat_o
);

    typedef struct packed {
        logic [W-1:0] prev;
        logic [W-1:0] stat;
    } bank_t;

    bank_t s_d, s_q;

    always_comb begin
        logic [W-1:0] clr;
        s_d      = s_q;
        set_o    = cond_i & ~s_q.prev;
        clr      = clr_we_i ? clr_mask_i : '0;
        s_d.prev = cond_i;
        // a new edge overrides a same-cycle clear
        s_d.stat = (s_q.stat & ~clr) | set_o;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign stat_o = s_q.stat;

endmodule

// File: rtl/qis_regfile.sv
module qis_regfile #(
    parameter int DATA_W  = 32,
    parameter int FIELD_W = 4,
    parameter int NQ      = 32,
    parameter int ADDR_W  = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_i,
    input  logic [ADDR_W-1:0]         addr_i,
    input  logic [DATA_W-1:0]         wdata_i,
    input  logic [DATA_W-1:0]         stat_lo_i,
    input  logic [DATA_W-1:0]         stat_hi_i,
    output logic [DATA_W-1:0]         rdata_o,
    output logic [NQ*FIELD_W-1:0]     src_o,
    output logic [DATA_W-1:0]         en_lo_o,
    output logic [DATA_W-1:0]         en_hi_o,
    output logic                      clr_lo_o,
    output logic                      clr_hi_o
);

    localparam int SRC_WORDS = NQ * FIELD_W / DATA_W;
    localparam int SW_W      = (SRC_WORDS > 1) ? $clog2(SRC_WORDS) : 1;
    localparam logic [ADDR_W-1:0] EN_LO_A   = ADDR_W'(SRC_WORDS);
    localparam logic [ADDR_W-1:0] EN_HI_A   = ADDR_W'(SRC_WORDS + 1);
    localparam logic [ADDR_W-1:0] STAT_LO_A = ADDR_W'(SRC_WORDS + 2);
    localparam logic [ADDR_W-1:0] STAT_HI_A = ADDR_W'(SRC_WORDS + 3);

    function automatic logic [DATA_W-1:0] legal_mask();
        logic [DATA_W-1:0] m;
        for (int i = 0; i < DATA_W; i++) m[i] = ((i % FIELD_W) != FIELD_W - 1);
        return m;
    endfunction

    localparam logic [DATA_W-1:0] LEGAL = legal_mask();

    typedef struct packed {
        logic [SRC_WORDS-1:0][DATA_W-1:0] src;
        logic [DATA_W-1:0]                en_lo;
        logic [DATA_W-1:0]                en_hi;
    } regs_t;

    regs_t r_d, r_q;
    logic  is_src;

    assign is_src = (addr_i < ADDR_W'(SRC_WORDS));

    always_comb begin
        r_d = r_q;
        if (wr_i) begin
            if (is_src)                  r_d.src[addr_i[SW_W-1:0]] = wdata_i & LEGAL;
            else if (addr_i == EN_LO_A)  r_d.en_lo = wdata_i;
            else if (addr_i == EN_HI_A)  r_d.en_hi = wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        rdata_o = '0;
        if (is_src)                     rdata_o = r_q.src[addr_i[SW_W-1:0]];
        else if (addr_i == EN_LO_A)     rdata_o = r_q.en_lo;
        else if (addr_i == EN_HI_A)     rdata_o = r_q.en_hi;
        else if (addr_i == STAT_LO_A)   rdata_o = stat_lo_i;
        else if (addr_i == STAT_HI_A)   rdata_o = stat_hi_i;
    end

    assign src_o    = r_q.src;
    assign en_lo_o  = r_q.en_lo;
    assign en_hi_o  = r_q.en_hi;
    assign clr_lo_o = wr_i && (addr_i == STAT_LO_A);
    assign clr_hi_o = wr_i && (addr_i == STAT_HI_A);

endmodule

// File: rtl/qis_top.sv
module qis_top
    import qis_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int FIELD_W = 4,
    parameter int ADDR_W  = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [2*DATA_W-1:0] q_empty,
    input  logic [2*DATA_W-1:0] q_near_empty,
    input  logic [2*DATA_W-1:0] q_near_full,
    input  logic [2*DATA_W-1:0] q_full,
    input  logic                reg_wr,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    output logic                irq_lo,
    output logic                irq_hi
);

    localparam int HALF_Q = DATA_W;

    logic [HALF_Q*FIELD_W-1:0] src_lo;
    logic [HALF_Q-1:0]         cond_lo, cond_hi;
    logic [DATA_W-1:0]         en_lo, en_hi, stat_lo, stat_hi;
    logic [HALF_Q-1:0]         set_lo, set_hi;
    logic                      clr_lo, clr_hi;

    qis_regfile #(.DATA_W(DATA_W), .FIELD_W(FIELD_W), .NQ(HALF_Q), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_i(reg_wr), .addr_i(reg_addr), .wdata_i(reg_wdata),
        .stat_lo_i(stat_lo), .stat_hi_i(stat_hi), .rdata_o(reg_rdata), .src_o(src_lo),
        .en_lo_o(en_lo), .en_hi_o(en_hi), .clr_lo_o(clr_lo), .clr_hi_o(clr_hi)
    );

    qis_cond_sel #(.NQ(HALF_Q), .FIELD_W(FIELD_W), .PROG(1'b1)) u_sel_lo (
        .src_i(src_lo),
        .empty_i(q_empty[HALF_Q-1:0]), .near_empty_i(q_near_empty[HALF_Q-1:0]),
        .near_full_i(q_near_full[HALF_Q-1:0]), .full_i(q_full[HALF_Q-1:0]),
        .cond_o(cond_lo)
    );

    qis_cond_sel #(.NQ(HALF_Q), .FIELD_W(FIELD_W), .PROG(1'b0),
                   .FIXED_CODE(CODE_NOT_NEAR_EMPTY)) u_sel_hi (
        .src_i('0),
        .empty_i(q_empty[2*HALF_Q-1:HALF_Q]), .near_empty_i(q_near_empty[2*HALF_Q-1:HALF_Q]),
        .near_full_i(q_near_full[2*HALF_Q-1:HALF_Q]), .full_i(q_full[2*HALF_Q-1:HALF_Q]),
        .cond_o(cond_hi)
    );

    qis_latch_bank #(.W(HALF_Q)) u_bank_lo (
        .clk(clk), .rst_n(rst_n), .cond_i(cond_lo), .clr_we_i(clr_lo),
        .clr_mask_i(reg_wdata), .set_o(set_lo), .stat_o(stat_lo)
    );

    qis_latch_bank #(.W(HALF_Q)) u_bank_hi (
        .clk(clk), .rst_n(rst_n), .cond_i(cond_hi), .clr_we_i(clr_hi),
        .clr_mask_i(reg_wdata), .set_o(set_hi), .stat_o(stat_hi)
    );

    assign irq_lo = |(stat_lo & en_lo);
    assign irq_hi = |(stat_hi & en_hi);

endmodule

// File: rtl/qis_checker.sv
module qis_checker #(
    parameter int DATA_W  = 32,
    parameter int FIELD_W = 4,
    parameter int ADDR_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic [DATA_W-1:0] reg_rdata,
    input logic [DATA_W-1:0] stat_lo,
    input logic [DATA_W-1:0] stat_hi,
    input logic [DATA_W-1:0] set_lo,
    input logic [DATA_W-1:0] set_hi,
    input logic [DATA_W-1:0] en_lo,
    input logic [DATA_W-1:0] en_hi,
    input logic              irq_lo,
    input logic              irq_hi
);

    localparam int SRC_WORDS = DATA_W * FIELD_W / DATA_W;
    localparam logic [ADDR_W-1:0] STAT_LO_A = ADDR_W'(SRC_WORDS + 2);
    localparam logic [ADDR_W-1:0] STAT_HI_A = ADDR_W'(SRC_WORDS + 3);

    function automatic logic [DATA_W-1:0] rsv_mask();
        logic [DATA_W-1:0] m;
        for (int i = 0; i < DATA_W; i++) m[i] = ((i % FIELD_W) == FIELD_W - 1);
        return m;
    endfunction
    localparam logic [DATA_W-1:0] RSV = rsv_mask();

    a_r3_reserved_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr < ADDR_W'(SRC_WORDS)) |-> ((reg_rdata & RSV) == '0));

    a_r5_sticky_lo: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_addr == STAT_LO_A) |=> ((stat_lo & $past(stat_lo)) == $past(stat_lo)));

    a_r5_sticky_hi: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_addr == STAT_HI_A) |=> ((stat_hi & $past(stat_hi)) == $past(stat_hi)));

    a_r6_clear_lo: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == STAT_LO_A) |=> ((stat_lo & $past(reg_wdata) & ~$past(set_lo)) == '0));

    a_r7_set_wins_lo: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((stat_lo & $past(set_lo)) == $past(set_lo)));

    a_r7_set_wins_hi: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((stat_hi & $past(set_hi)) == $past(set_hi)));

    a_r8_quiet_lo: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat_lo & en_lo) == '0) |-> !irq_lo);

    a_r8_quiet_hi: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat_hi & en_hi) == '0) |-> !irq_hi);

endmodule

bind qis_top qis_checker #(.DATA_W(DATA_W), .FIELD_W(FIELD_W), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .stat_lo(stat_lo), .stat_hi(stat_hi), .set_lo(set_lo),
    .set_hi(set_hi), .en_lo(en_lo), .en_hi(en_hi), .irq_lo(irq_lo), .irq_hi(irq_hi)
);

// File: tb/tb_qis_top.sv
module tb_qis_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] fe = '0, fne = '1, fnf = '0, ff = '0;
    logic        wr = 1'b0;
    logic [2:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq_lo, irq_hi;
    int          checks = 0;
    int          errors = 0;

    always #2 clk = ~clk;

    qis_top dut (
        .clk(clk), .rst_n(rst_n), .q_empty(fe), .q_near_empty(fne),
        .q_near_full(fnf), .q_full(ff), .reg_wr(wr), .reg_addr(addr),
        .reg_wdata(wdata), .reg_rdata(rdata), .irq_lo(irq_lo), .irq_hi(irq_hi)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wreg(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic rreg(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        for (int a = 0; a < 8; a++) begin
            rreg(3'(a), v);
            chk("R1 reset read", v, 32'h0);
        end
        chk("R1 irq_lo reset", {31'b0, irq_lo}, 32'h0);
        chk("R1 irq_hi reset", {31'b0, irq_hi}, 32'h0);
    endtask

    task automatic t_select();
        logic [31:0] v;
        wreg(3'd0, 32'h2 << 20);             // queue 5: nearly full
        wreg(3'd4, 32'h1 << 5);
        rreg(3'd4, v);
        chk("R9 enable readback", v, 32'h1 << 5);
        @(negedge clk); fnf[5] = 1'b1;
        rreg(3'd6, v);
        chk("R2 queue5 nearly full latched", v, 32'h1 << 5);
        chk("R8 irq_lo enabled", {31'b0, irq_lo}, 32'h1);
        wreg(3'd6, 32'h1 << 5);
        rreg(3'd6, v);
        chk("R6 write-1 clear", v, 32'h0);
        repeat (2) @(negedge clk);
        rreg(3'd6, v);
        chk("R5 held-high no reset", v, 32'h0);
        fnf[5] = 1'b0;
        wreg(3'd1, 32'h6 << 20);             // queue 13: not nearly full
        rreg(3'd6, v);
        chk("R2 queue13 inverted source", v, 32'h1 << 13);
        wreg(3'd6, 32'h1 << 13);
        @(negedge clk); fnf[13] = 1'b1;
        rreg(3'd6, v);
        chk("R2 inverted falls no set", v, 32'h0);
        @(negedge clk); fnf[13] = 1'b0;
        rreg(3'd6, v);
        chk("R2 inverted rises set", v, 32'h1 << 13);
        wreg(3'd1, 32'h0);
        wreg(3'd6, 32'hFFFF_FFFF);
        rreg(3'd6, v);
        chk("R6 clear all", v, 32'h0);
    endtask

    task automatic t_reserved();
        logic [31:0] v;
        wreg(3'd3, 32'hFFFF_FFFF);
        rreg(3'd3, v);
        chk("R3 reserved bits dropped", v, 32'h7777_7777);
        rreg(3'd6, v);
        chk("R2 not-full code on 24..31", v, 32'hFF00_0000);
        chk("R8 irq_lo masked", {31'b0, irq_lo}, 32'h0);
        wreg(3'd3, 32'h0);
        wreg(3'd6, 32'hFFFF_FFFF);
        rreg(3'd6, v);
        chk("R6 clear after reserved", v, 32'h0);
    endtask

    task automatic t_upper();
        logic [31:0] v;
        wreg(3'd2, 32'h5555_5555);           // lower source writes, flags quiet
        @(negedge clk); fne[40] = 1'b0;
        rreg(3'd7, v);
        chk("R4 upper not nearly empty", v, 32'h1 << 8);
        chk("R8 irq_hi not enabled", {31'b0, irq_hi}, 32'h0);
        wreg(3'd5, 32'h1 << 8);
        rreg(3'd5, v);
        chk("R9 enable hi readback", v, 32'h1 << 8);
        chk("R8 irq_hi enabled", {31'b0, irq_hi}, 32'h1);
        @(negedge clk); fne[40] = 1'b1;
        rreg(3'd7, v);
        chk("R5 sticky after fall", v, 32'h1 << 8);
        wreg(3'd7, 32'h0);
        rreg(3'd7, v);
        chk("R6 write zero keeps", v, 32'h1 << 8);
        wreg(3'd7, 32'h1 << 8);
        rreg(3'd7, v);
        chk("R6 upper clear", v, 32'h0);
        chk("R8 irq_hi drops", {31'b0, irq_hi}, 32'h0);
        rreg(3'd6, v);
        chk("R4 lower untouched", v, 32'h0);
        wreg(3'd2, 32'h0);
    endtask

    task automatic t_set_wins();
        logic [31:0] v;
        @(negedge clk);
        fne[41] = 1'b0;
        wr = 1'b1; addr = 3'd7; wdata = 32'h1 << 9;
        @(negedge clk);
        wr = 1'b0;
        rreg(3'd7, v);
        chk("R7 set beats clear", v, 32'h1 << 9);
        wreg(3'd7, 32'h1 << 9);
        rreg(3'd7, v);
        chk("R7 later clear works", v, 32'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_select();
        t_reserved();
        t_upper();
        t_set_wins();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule